// File: doc/BRIEF.md
# Edge-Change Interrupt Controller

This block watches a bank of digital input lines for transitions and turns selected transitions into one interrupt line. The lines form 8-bit ports. Each bit has two enable masks, one for rising and one for falling transitions. A control register adds a global switch for each direction and enables for the interrupt sources. The lines are first brought into the clock domain by a two-flop synchronizer. Each line is then compared with its value one cycle earlier. Any enabled transition sets a sticky edge flag. If another enabled transition arrives while that flag is still set, an overflow flag is set as well.

Software uses a byte-wide register bus. Writes take effect on the clock edge where the write strobe is high. Reads are registered: the read data updates on the clock edge where the read strobe is high and holds between reads. An interrupt handler reads the status register and serves the event only when the master bit is set. It then writes the clear register, which is write-only, to drop the edge flag, the overflow flag, or both in one access. Every register resets to zero.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0x00 and `irq` is low.
- R2: Port p (0..NUM_PORTS-1) owns input bits 8p+7..8p. Its rising-enable mask is at address 0x42+0x10*p and its falling-enable mask at 0x43+0x10*p. Bit k of each mask belongs to input bit 8p+k. Both masks read back what was written.
- R3: Status register 0x02 has the edge flag in bit 0. The flag is set when a line goes 0 to 1 while its rising-enable bit and control bit 3 are both set. It is also set when a line goes 1 to 0 while its falling-enable bit and control bit 4 are both set.
- R4: A transition on a line whose enable bit for that direction is clear, or whose direction is switched off in control bit 3 or 4, leaves the status register unchanged.
- R5: Status bit 1 (overflow) is set when an enabled transition arrives while the edge flag is already set.
- R6: A write to clear register 0x01 with data bit 1 set clears the edge flag, and with data bit 2 set clears the overflow flag. Both may be cleared in one write. If a new enabled transition is detected in the same cycle as the clear, the flag stays set.
- R7: Status bit 2 equals control bit 2 AND ((edge flag AND control bit 0) OR (overflow flag AND control bit 1)). `irq` always equals status bit 2.
- R8: When the control register (address 0x03) holds 0x00, `irq` is low and no transition is detected.
- R9: An input change driven before clock edge n appears in the status register and on `irq` after clock edge n+2, not earlier.
- R10: The clear register and any unmapped address read as 0x00. `bus_rdata` changes only on clock edges where `bus_re` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one access per high cycle |
| bus_re | input | 1 | Read strobe; read data is registered |
| bus_rdata | output | 8 | Read data |
| lines_in | input | 8*NUM_PORTS | Asynchronous input lines |
| irq | output | 1 | Interrupt, level high |

## Verification
The main sweep visits all 32 lines one at a time. In each pass only the line under test is enabled. That line is toggled in both directions and its neighbouring line is toggled too. This separates a wrong bit-to-port mapping from leakage out of the enable masks. Further patterns enable only one direction, or switch a direction off globally, to tell the per-bit masks apart from the control switches. Back-to-back transitions without a clear, single-bit and two-bit clears, and a clear that lands in the same cycle as a new transition separate the overflow rule from the clear priority. The interrupt is stepped through every enable combination, and the exact cycle of its first rise is checked against the synchronizer depth.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int PORT_W = 8;

  localparam logic [7:0] ADDR_CLEAR  = 8'h01;
  localparam logic [7:0] ADDR_STATUS = 8'h02;
  localparam logic [7:0] ADDR_CTRL   = 8'h03;
  localparam logic [7:0] ADDR_RISE0  = 8'h42;
  localparam logic [7:0] ADDR_FALL0  = 8'h43;
  localparam logic [7:0] PORT_STRIDE = 8'h10;

  localparam int CLR_EDGE_BIT = 1;
  localparam int CLR_OVF_BIT  = 2;

  // bit4..bit0 of the control register
  typedef struct packed {
    logic fall_on;
    logic rise_on;
    logic master_ie;
    logic ovf_ie;
    logic edge_ie;
  } ctl_t;

  function automatic logic [7:0] port_addr(input logic [7:0] base, input int p);
    return base + PORT_STRIDE * 8'(p);
  endfunction
endpackage

// File: rtl/eic_input_sync.sv
module eic_input_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_in,
  output logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] prev
);
  logic [WIDTH-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign cur  = sync_q;
  assign prev = prev_q;
endmodule

// File: rtl/eic_edge_detect.sv
module eic_edge_detect #(
  parameter int NUM_PORTS = 4,
  localparam int WIDTH = NUM_PORTS * eic_pkg::PORT_W
) (
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] prev,
  input  logic [WIDTH-1:0] rise_mask,
  input  logic [WIDTH-1:0] fall_mask,
  input  logic             rise_on,
  input  logic             fall_on,
  output logic             hit
);
  localparam int PW = eic_pkg::PORT_W;
  logic [NUM_PORTS-1:0] port_hit;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [PW-1:0] up, down;
    assign up   = cur[p*PW +: PW] & ~prev[p*PW +: PW] & rise_mask[p*PW +: PW]
                  & {PW{rise_on}};
    assign down = ~cur[p*PW +: PW] & prev[p*PW +: PW] & fall_mask[p*PW +: PW]
                  & {PW{fall_on}};
    assign port_hit[p] = |(up | down);
  end

  assign hit = |port_hit;
endmodule

// File: rtl/eic_status.sv
module eic_status (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic          clr_edge,
  input  logic          clr_ovf,
  input  eic_pkg::ctl_t ctl,
  output logic          edge_st,
  output logic          ovf_st,
  output logic          master_st
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      edge_st <= 1'b0;
      ovf_st  <= 1'b0;
    end else begin
      // a detection in the same cycle beats a clear
      edge_st <= hit | (edge_st & ~clr_edge);
      ovf_st  <= (hit & edge_st) | (ovf_st & ~clr_ovf);
    end
  end

  assign master_st = ctl.master_ie & ((edge_st & ctl.edge_ie) | (ovf_st & ctl.ovf_ie));
endmodule

// File: rtl/eic_cfg_regs.sv
module eic_cfg_regs #(
  parameter int NUM_PORTS = 4,
  localparam int WIDTH = NUM_PORTS * eic_pkg::PORT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  input  logic             bus_we,
  input  logic             bus_re,
  input  logic             edge_st,
  input  logic             ovf_st,
  input  logic             master_st,
  output eic_pkg::ctl_t    ctl,
  output logic [WIDTH-1:0] rise_mask,
  output logic [WIDTH-1:0] fall_mask,
  output logic             clr_edge,
  output logic             clr_ovf,
  output logic [7:0]       bus_rdata
);
  import eic_pkg::*;
  localparam int PW = PORT_W;

  ctl_t             ctl_q;
  logic [WIDTH-1:0] rise_q, fall_q;
  logic [7:0]       rd_next, rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
    end else if (bus_we) begin
      if (bus_addr == ADDR_CTRL) ctl_q <= ctl_t'(bus_wdata[4:0]);
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (bus_addr == port_addr(ADDR_RISE0, p)) rise_q[p*PW +: PW] <= bus_wdata;
        if (bus_addr == port_addr(ADDR_FALL0, p)) fall_q[p*PW +: PW] <= bus_wdata;
      end
    end
  end

  always_comb begin
    rd_next = 8'h00;
    if (bus_addr == ADDR_STATUS) rd_next = {5'b0, master_st, ovf_st, edge_st};
    if (bus_addr == ADDR_CTRL)   rd_next = {3'b0, ctl_q};
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (bus_addr == port_addr(ADDR_RISE0, p)) rd_next = rise_q[p*PW +: PW];
      if (bus_addr == port_addr(ADDR_FALL0, p)) rd_next = fall_q[p*PW +: PW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata_q <= 8'h00;
    else if (bus_re) rdata_q <= rd_next;
  end

  assign clr_edge  = bus_we && (bus_addr == ADDR_CLEAR) && bus_wdata[CLR_EDGE_BIT];
  assign clr_ovf   = bus_we && (bus_addr == ADDR_CLEAR) && bus_wdata[CLR_OVF_BIT];
  assign ctl       = ctl_q;
  assign rise_mask = rise_q;
  assign fall_mask = fall_q;
  assign bus_rdata = rdata_q;
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl #(
  parameter int NUM_PORTS = 4,
  localparam int LINES = NUM_PORTS * eic_pkg::PORT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  input  logic             bus_we,
  input  logic             bus_re,
  output logic [7:0]       bus_rdata,
  input  logic [LINES-1:0] lines_in,
  output logic             irq
);
  eic_pkg::ctl_t    ctl;
  logic [LINES-1:0] cur, prev, rise_mask, fall_mask;
  logic             hit, clr_edge, clr_ovf, edge_st, ovf_st, master_st;

  eic_input_sync #(.WIDTH(LINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_in(lines_in), .cur(cur), .prev(prev)
  );

  eic_edge_detect #(.NUM_PORTS(NUM_PORTS)) u_detect (
    .cur(cur), .prev(prev), .rise_mask(rise_mask), .fall_mask(fall_mask),
    .rise_on(ctl.rise_on), .fall_on(ctl.fall_on), .hit(hit)
  );

  eic_status u_status (
    .clk(clk), .rst_n(rst_n), .hit(hit), .clr_edge(clr_edge), .clr_ovf(clr_ovf),
    .ctl(ctl), .edge_st(edge_st), .ovf_st(ovf_st), .master_st(master_st)
  );

  eic_cfg_regs #(.NUM_PORTS(NUM_PORTS)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .edge_st(edge_st), .ovf_st(ovf_st),
    .master_st(master_st), .ctl(ctl), .rise_mask(rise_mask), .fall_mask(fall_mask),
    .clr_edge(clr_edge), .clr_ovf(clr_ovf), .bus_rdata(bus_rdata)
  );

  assign irq = master_st;
endmodule

// File: rtl/eic_checker.sv
module eic_checker (
  input logic          clk,
  input logic          rst_n,
  input logic          irq,
  input eic_pkg::ctl_t ctl,
  input logic          edge_st,
  input logic          ovf_st,
  input logic          hit,
  input logic          clr_edge,
  input logic          clr_ovf
);
  AST_IRQ_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.master_ie |-> !irq); // R7
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (edge_st || ovf_st)); // R7
  AST_CTL_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl == '0) |-> (!irq && !hit)); // R8
  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> edge_st); // R3
  AST_OVF_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_st) |-> $past(edge_st)); // R5
  AST_EDGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_edge && !hit) |=> !edge_st); // R6
  AST_OVF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ovf && !(hit && edge_st)) |=> !ovf_st); // R6
  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_st && !clr_edge) |=> edge_st); // R6
endmodule

bind edge_irq_ctrl eic_checker u_eic_checker (
  .clk(clk), .rst_n(rst_n), .irq(irq), .ctl(ctl), .edge_st(edge_st),
  .ovf_st(ovf_st), .hit(hit), .clr_edge(clr_edge), .clr_ovf(clr_ovf)
);

// File: tb/test_edge_irq_ctrl.sv
`timescale 1ns/1ps
module test_edge_irq_ctrl;
  localparam int NP = 4;
  localparam int NL = NP * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    bus_addr = '0, bus_wdata = '0;
  logic          bus_we = 1'b0, bus_re = 1'b0;
  logic [7:0]    bus_rdata;
  logic [NL-1:0] lines = '0;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  edge_irq_ctrl #(.NUM_PORTS(NP)) i_edge_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .lines_in(lines), .irq(irq)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_lines(input logic [NL-1:0] v);
    @(negedge clk);
    lines = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_status(input string req, input logic [7:0] exp);
    logic [7:0] s;
    rd(8'h02, s);
    chk(req, "status", s, exp);
    chk(req, "irq", irq, exp[2]);
  endtask

  task automatic set_masks(input logic [NL-1:0] r, input logic [NL-1:0] f);
    for (int p = 0; p < NP; p++) begin
      wr(8'h42 + 8'(p * 16), r[p*8 +: 8]);
      wr(8'h43 + 8'(p * 16), f[p*8 +: 8]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    chk("R1", "irq after reset", irq, 1'b0);
    chk("R1", "rdata after reset", bus_rdata, 8'h00);
    rd(8'h02, d); chk("R1", "status", d, 8'h00);
    rd(8'h03, d); chk("R1", "control", d, 8'h00);
    for (int p = 0; p < NP; p++) begin
      rd(8'h42 + 8'(p * 16), d); chk("R1", "rise mask", d, 8'h00);
      rd(8'h43 + 8'(p * 16), d); chk("R1", "fall mask", d, 8'h00);
    end

    // R2: mask readback per port
    for (int p = 0; p < NP; p++) begin
      wr(8'h42 + 8'(p * 16), 8'hA0 | 8'(p));
      wr(8'h43 + 8'(p * 16), 8'h50 | 8'(p));
    end
    for (int p = 0; p < NP; p++) begin
      rd(8'h42 + 8'(p * 16), d); chk("R2", "rise readback", d, 8'hA0 | 8'(p));
      rd(8'h43 + 8'(p * 16), d); chk("R2", "fall readback", d, 8'h50 | 8'(p));
    end

    // R10: unmapped and clear register read as zero, rdata holds
    rd(8'h01, d); chk("R10", "clear reg read", d, 8'h00);
    rd(8'h10, d); chk("R10", "unmapped read", d, 8'h00);
    rd(8'h42, d);
    @(negedge clk); bus_addr = 8'h43;
    @(negedge clk); chk("R10", "rdata holds without re", bus_rdata, 8'hA0);

    // R3/R4/R2: sweep every line, one enabled at a time
    wr(8'h03, 8'h1F);
    for (int b = 0; b < NL; b++) begin
      logic [NL-1:0] one, nb;
      one = NL'(1) << b;
      nb  = NL'(1) << ((b + 1) % NL);
      set_masks(one, one);
      set_lines(one);
      chk_status("R3", 8'h05);           // rising edge on enabled bit
      wr(8'h01, 8'h06);
      set_lines(one | nb);
      set_lines(one);
      chk_status("R4", 8'h00);           // neighbour toggled, not enabled
      set_lines('0);
      chk_status("R3", 8'h05);           // falling edge on enabled bit
      wr(8'h01, 8'h06);
    end

    // R4: per-direction masks and global direction switches
    set_masks('1, '0);
    set_lines(NL'(8));
    set_lines('0);
    chk_status("R4", 8'h05);             // rise seen, fall ignored by mask
    wr(8'h01, 8'h02);
    chk_status("R6", 8'h00);
    set_masks('1, '1);
    wr(8'h03, 8'h17);                    // rising switched off
    set_lines(NL'(8));
    chk_status("R4", 8'h00);
    set_lines('0);
    chk_status("R3", 8'h05);             // falling still on
    wr(8'h01, 8'h06);
    wr(8'h03, 8'h0F);                    // falling switched off
    set_lines(NL'(1) << 20);
    set_lines('0);
    chk_status("R4", 8'h05);
    wr(8'h01, 8'h06);

    // R9: latency of detection
    wr(8'h03, 8'h1F);
    @(negedge clk); lines = NL'(1) << 31;
    @(negedge clk); chk("R9", "irq after 1 edge", irq, 1'b0);
    @(negedge clk); chk("R9", "irq after 2 edges", irq, 1'b0);
    @(negedge clk); chk("R9", "irq after 3 edges", irq, 1'b1);

    // R5: overflow on second event
    set_lines('0);
    chk_status("R5", 8'h07);
    // R6: single-bit clears
    wr(8'h01, 8'h02);
    chk_status("R6", 8'h06);             // overflow remains, still interrupting
    wr(8'h01, 8'h04);
    chk_status("R6", 8'h00);
    set_lines(NL'(2));
    set_lines('0);
    chk_status("R5", 8'h07);
    wr(8'h01, 8'h06);
    chk_status("R6", 8'h00);

    // R7: interrupt enable combinations with only edge pending
    set_lines(NL'(2));
    wr(8'h03, 8'h1B); chk_status("R7", 8'h01);  // master off
    wr(8'h03, 8'h1E); chk_status("R7", 8'h01);  // edge ie off
    wr(8'h03, 8'h1D); chk_status("R7", 8'h05);
    set_lines('0);                               // now overflow too
    wr(8'h03, 8'h1E); chk_status("R7", 8'h07);  // overflow source alone
    wr(8'h03, 8'h1A); chk_status("R7", 8'h03);

    // R8: control zero
    wr(8'h03, 8'h00);
    chk_status("R8", 8'h03);
    wr(8'h01, 8'h06);
    set_lines(NL'(4));
    set_lines('0);
    chk_status("R8", 8'h00);

    // R6: clear collides with a new detection
    wr(8'h03, 8'h1F);
    set_lines(NL'(1));
    @(negedge clk); lines = '0;
    @(negedge clk);
    @(negedge clk); bus_addr = 8'h01; bus_wdata = 8'h02; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
    chk_status("R6", 8'h07);             // edge kept, overflow set
    wr(8'h01, 8'h06);
    chk_status("R6", 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule